// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It watches three input lines: a bit clock, a word-select line that toggles once per channel, and a serial data line. All three are oversampled by the block's own system clock. A two-bit format select picks one of four framings: left justified, I2S, right justified with 24 data bits, or right justified with 16 data bits. After a complete left word and then a complete right word have arrived, both samples appear together on 24-bit outputs, MSB aligned, with a one-cycle valid strobe.

The bit timing can come from an external bit clock. It can also come from an internal bit-tick generator that counts system clocks and re-aligns its phase on every word-select edge. A parameter chooses between the two. In both cases the word capture and pairing logic after the tick source is the same, so the samples produced are the same.

A word counts as finished when the next half-frame begins. That gives one rule for all four framings and puts the strobe at a fixed point relative to the word-select edge.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 00 (left justified), the MSB is the first bit sampled after a word-select transition, and word-select high marks the left channel.
- R2: With format code 01 (I2S), the MSB is the second bit sampled after a word-select transition, and word-select low marks the left channel. A 24-bit word may end on the first bit after the following transition.
- R3: With format code 10 (right justified, long), the sample is the last 24 bits before the word-select transition, and earlier bits of the half-frame are dropped. Word-select high marks the left channel.
- R4: With format code 11 (right justified, short), the last 16 bits before the transition fill output bits [23:8], and bits [7:0] are zero. Word-select high marks the left channel.
- R5: Data is sampled once per rising bit-clock edge. In the justified formats a word shorter than 24 bits, followed by zero bits, appears left-aligned with zero low bits, and bits past the 24th of a half-frame are ignored.
- R6: `pair_valid` is high for exactly one cycle once a right word has completed after a left word. Both sample outputs update in that cycle and hold their values at all other times.
- R7: The partial half-frame in progress when reset is released is discarded. No strobe occurs until a full left word and then a full right word have arrived.
- R8: While reset is high and just after it is released, both sample outputs are zero and `pair_valid` is low.
- R9: With the internal bit-tick option and a bit period of `CLKS_PER_BIT` system clocks, the block produces the same sample pairs as with an external bit clock carrying the same stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock; ignored when the internal tick option is selected |
| lrck_i | input | 1 | Word-select (channel) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing select: 00 left justified, 01 I2S, 10 right justified 24, 11 right justified 16 |
| left_o | output | WORD_W | Left sample, MSB aligned |
| right_o | output | WORD_W | Right sample, MSB aligned |
| pair_valid | output | 1 | One-cycle strobe when a new stereo pair is on the outputs |

## Verification
The stream is driven in all four framings with random sample values. Random junk is placed in every bit slot outside the word, so a wrong word offset, a wrong channel polarity, or a right-justified window taken from the wrong end all show up as mismatched values. Half-frames of exactly the word length (24 bits for I2S and right justified 24, 16 bits for right justified 16) are set against 32-bit half-frames. These separate correct edge-relative counting from counting that only works when there are spare bits, and they include the I2S case where the LSB falls after the word-select edge. A 20-bit left-justified word followed by zero padding and junk past bit 24 shows whether zero fill works and whether trailing bits are ignored. A second instance with the internal bit tick receives the same stream, so any difference between the two tick sources appears as a mismatch against the same expected pairs.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      FMT_LJ       = 2'b00,
      FMT_I2S      = 2'b01,
      FMT_RJ_LONG  = 2'b10,
      FMT_RJ_SHORT = 2'b11
   } fmt_e;
endpackage

// File: rtl/sar_bit_clock.sv
module sar_bit_clock #(
   parameter int SYNC_STAGES  = 2,
   parameter bit EXT_BCLK     = 1'b1,
   parameter int CLKS_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic bclk_i,
   input  logic lrck_i,
   input  logic sdata_i,
   output logic tick_o,
   output logic lr_o,
   output logic dat_o
);
   localparam int CNT_W   = $clog2(CLKS_PER_BIT);
   localparam int TICK_AT = CLKS_PER_BIT / 2 - 1;

   initial begin
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (CLKS_PER_BIT >= 4) else $error("CLKS_PER_BIT must be at least 4");
   end

   logic [SYNC_STAGES-1:0] lr_sync, dat_sync;

   always_ff @(posedge clk) begin
      if (rst) begin
         lr_sync  <= '0;
         dat_sync <= '0;
      end else begin
         lr_sync[0]  <= lrck_i;
         dat_sync[0] <= sdata_i;
         for (int i = 1; i < SYNC_STAGES; i++) begin
            lr_sync[i]  <= lr_sync[i-1];
            dat_sync[i] <= dat_sync[i-1];
         end
      end
   end

   assign lr_o  = lr_sync[SYNC_STAGES-1];
   assign dat_o = dat_sync[SYNC_STAGES-1];

   generate
      if (EXT_BCLK) begin : g_ext
         logic [SYNC_STAGES-1:0] bc_sync;
         logic                   bc_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               bc_sync <= '0;
               bc_q    <= 1'b0;
            end else begin
               bc_sync[0] <= bclk_i;
               for (int i = 1; i < SYNC_STAGES; i++) bc_sync[i] <= bc_sync[i-1];
               bc_q <= bc_sync[SYNC_STAGES-1];
            end
         end
         assign tick_o = bc_sync[SYNC_STAGES-1] & ~bc_q;
      end else begin : g_int
         logic             lr_q;
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) begin
               lr_q <= 1'b0;
               cnt  <= '0;
            end else begin
               lr_q <= lr_o;
               if (lr_o != lr_q || cnt == CNT_W'(CLKS_PER_BIT - 1)) cnt <= '0;
               else cnt <= cnt + 1'b1;
            end
         end
         assign tick_o = (cnt == CNT_W'(TICK_AT)) && (lr_o == lr_q);
      end
   endgenerate

   // R5
   tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);
endmodule

// File: rtl/sar_word_capture.sv
module sar_word_capture
   import sar_pkg::*;
#(
   parameter int WORD_W  = 24,
   parameter int SHORT_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic              lr_i,
   input  logic              dat_i,
   input  fmt_e              fmt_i,
   output logic              done_o,
   output logic              done_left_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int POS_W = $clog2(WORD_W + 1);
   localparam int PAD_W = WORD_W - SHORT_W;

   initial begin
      assert (SHORT_W > 0 && SHORT_W < WORD_W) else $error("SHORT_W must be below WORD_W");
   end

   logic              lr_prev, f_prev, started, cur_left;
   logic [1:0]        prime_cnt;
   logic [POS_W-1:0]  pos;
   logic [WORD_W-1:0] acc, acc_shift, acc_start, acc_step, finished;
   logic              justified, frame_lvl, chan_left, primed, boundary;

   always_comb begin
      justified = (fmt_i == FMT_LJ) || (fmt_i == FMT_I2S);
      // I2S framing runs one bit behind word-select, with inverted channel polarity
      frame_lvl = (fmt_i == FMT_I2S) ? lr_prev : lr_i;
      chan_left = (fmt_i == FMT_I2S) ? ~frame_lvl : frame_lvl;
      primed    = (prime_cnt == 2'd2);
      boundary  = primed && (frame_lvl != f_prev);
      acc_shift = {acc[WORD_W-2:0], dat_i};
      acc_start = justified ? {dat_i, {(WORD_W-1){1'b0}}} : acc_shift;
      acc_step  = acc_shift;
      if (justified) begin
         acc_step = acc;
         for (int b = 0; b < WORD_W; b++)
            if (int'(pos) == WORD_W - 1 - b) acc_step[b] = dat_i;
      end
      case (fmt_i)
         FMT_RJ_SHORT: finished = {acc[SHORT_W-1:0], {PAD_W{1'b0}}};
         default:      finished = acc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lr_prev     <= 1'b0;
         f_prev      <= 1'b0;
         prime_cnt   <= 2'd0;
         started     <= 1'b0;
         cur_left    <= 1'b0;
         pos         <= '0;
         acc         <= '0;
         done_o      <= 1'b0;
         done_left_o <= 1'b0;
         word_o      <= '0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            lr_prev <= lr_i;
            f_prev  <= frame_lvl;
            if (!primed) prime_cnt <= prime_cnt + 2'd1;
            if (boundary) begin
               if (started) begin
                  done_o      <= 1'b1;
                  done_left_o <= cur_left;
                  word_o      <= finished;
               end
               started  <= 1'b1;
               cur_left <= chan_left;
               pos      <= POS_W'(1);
               acc      <= acc_start;
            end else begin
               if (pos != POS_W'(WORD_W)) pos <= pos + 1'b1;
               acc <= acc_step;
            end
         end
      end
   end

   // R5
   done_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> $past(tick_i));
   // R4
   short_pad_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && fmt_i == FMT_RJ_SHORT) |-> (word_o[PAD_W-1:0] == '0));
endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done_i,
   input  logic              left_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);
   logic [WORD_W-1:0] held_left;
   logic              have_left;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_left <= '0;
         have_left <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (done_i) begin
            if (left_i) begin
               held_left <= word_i;
               have_left <= 1'b1;
            end else if (have_left) begin
               left_o    <= held_left;
               right_o   <= word_i;
               valid_o   <= 1'b1;
               have_left <= 1'b0;
            end
         end
      end
   end

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);
   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(left_o) || !$stable(right_o)) |-> valid_o);
   // R7
   pair_order_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> ($past(done_i) && !$past(left_i)));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
   parameter int WORD_W       = 24,
   parameter int SHORT_W      = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit EXT_BCLK     = 1'b1,
   parameter int CLKS_PER_BIT = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bclk_i,
   input  logic              lrck_i,
   input  logic              sdata_i,
   input  logic [1:0]        fmt_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              pair_valid
);
   logic              tick, lr_s, dat_s, done, done_left;
   logic [WORD_W-1:0] word;

   sar_bit_clock #(
      .SYNC_STAGES (SYNC_STAGES),
      .EXT_BCLK    (EXT_BCLK),
      .CLKS_PER_BIT(CLKS_PER_BIT)
   ) u_clk (
      .clk    (clk),
      .rst    (rst),
      .bclk_i (bclk_i),
      .lrck_i (lrck_i),
      .sdata_i(sdata_i),
      .tick_o (tick),
      .lr_o   (lr_s),
      .dat_o  (dat_s)
   );

   sar_word_capture #(
      .WORD_W (WORD_W),
      .SHORT_W(SHORT_W)
   ) u_cap (
      .clk        (clk),
      .rst        (rst),
      .tick_i     (tick),
      .lr_i       (lr_s),
      .dat_i      (dat_s),
      .fmt_i      (sar_pkg::fmt_e'(fmt_i)),
      .done_o     (done),
      .done_left_o(done_left),
      .word_o     (word)
   );

   sar_pair_out #(
      .WORD_W(WORD_W)
   ) u_out (
      .clk    (clk),
      .rst    (rst),
      .done_i (done),
      .left_i (done_left),
      .word_i (word),
      .left_o (left_o),
      .right_o(right_o),
      .valid_o(pair_valid)
   );
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
   logic        clk = 1'b0, rst = 1'b1, bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic [23:0] l_e, r_e, l_i, r_i;
   logic        v_e, v_i;
   int          checks = 0, failures = 0;
   bit          run_done = 1'b0;
   string       cur_req = "R8";
   logic [47:0] exp_q[$], exp_qi[$];
   logic [47:0] pop_e, pop_i;
   logic [31:0] seed = 32'h1357_9bdf;

   always #2 clk = ~clk;

   serial_audio_rx #(.EXT_BCLK(1'b1)) uut (
      .clk(clk), .rst(rst), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata), .fmt_i(fmt),
      .left_o(l_e), .right_o(r_e), .pair_valid(v_e));

   serial_audio_rx #(.EXT_BCLK(1'b0), .CLKS_PER_BIT(8)) uut_int (
      .clk(clk), .rst(rst), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata), .fmt_i(fmt),
      .left_o(l_i), .right_o(r_i), .pair_valid(v_i));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   // one bit period = 8 system clocks: 4 low, 4 high; lines change while bclk is low
   task automatic send_bit(input logic l, input logic d);
      @(negedge clk);
      bclk = 1'b0; lrck = l; sdata = d;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_segment(input logic [1:0] f, input int H, input int W,
                              input int npairs, input string req);
      logic        lq[$];
      logic        dq[$];
      logic        lp;
      logic [31:0] r;
      logic [23:0] v, ev, lv;
      int          off, s;
      rst = 1'b1; fmt = f; lp = (f == 2'b01) ? 1'b0 : 1'b1;
      lrck = ~lp; bclk = 1'b0; sdata = 1'b0;
      repeat (6) @(negedge clk);
      rst = 1'b0; cur_req = req;
      @(negedge clk);
      check(!v_e && l_e == 0 && r_e == 0, "R8", "reset state ext", {l_e, r_e}, 48'h0);
      check(!v_i && l_i == 0 && r_i == 0, "R8", "reset state int", {l_i, r_i}, 48'h0);
      // lead-in partial half-frame on the right channel, then frames, then a trailer
      for (int i = 0; i < 5; i++) begin r = rnd(); lq.push_back(~lp); dq.push_back(r[7]); end
      for (int k = 0; k < 2 * npairs; k++)
         for (int i = 0; i < H; i++) begin
            r = rnd(); lq.push_back((k % 2 == 0) ? lp : ~lp); dq.push_back(r[9]);
         end
      for (int i = 0; i < 6; i++) begin r = rnd(); lq.push_back(lp); dq.push_back(r[11]); end
      off = (f == 2'b00) ? 0 : (f == 2'b01) ? 1 : H - W;
      for (int k = 0; k < 2 * npairs; k++) begin
         r = rnd();
         v = 24'(r[23:0] >> (24 - W));
         s = 5 + k * H;
         for (int i = 0; i < W; i++) dq[s + off + i] = v[W - 1 - i];
         if (f[1] == 1'b0)
            for (int i = off + W; i < 24; i++) if (i < H + 1) dq[s + i] = 1'b0;
         ev = v << (24 - W);
         if (k % 2 == 0) lv = ev;
         else begin
            exp_q.push_back({lv, ev});
            exp_qi.push_back({lv, ev});
         end
      end
      foreach (lq[i]) send_bit(lq[i], dq[i]);
      @(negedge clk); bclk = 1'b0;
      repeat (60) @(negedge clk);
      check(exp_q.size() == 0, "R6", "pairs missing ext", 48'(exp_q.size()), 48'h0);
      check(exp_qi.size() == 0, "R9", "pairs missing int", 48'(exp_qi.size()), 48'h0);
      exp_q.delete(); exp_qi.delete();
   endtask

   // reference comparison on every clock
   always @(negedge clk) begin
      if (!rst) begin
         if (v_e) begin
            if (exp_q.size() == 0) check(1'b0, "R7", "unexpected strobe ext", {l_e, r_e}, 48'h0);
            else begin
               pop_e = exp_q.pop_front();
               check({l_e, r_e} == pop_e, cur_req, "pair ext", {l_e, r_e}, pop_e);
            end
         end
         if (v_i) begin
            if (exp_qi.size() == 0) check(1'b0, "R9", "unexpected strobe int", {l_i, r_i}, 48'h0);
            else begin
               pop_i = exp_qi.pop_front();
               check({l_i, r_i} == pop_i, {"R9 ", cur_req}, "pair int", {l_i, r_i}, pop_i);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!run_done) begin
         failures++;
         $display("FAIL R6 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      run_segment(2'b00, 32, 24, 3, "R1");
      run_segment(2'b00, 32, 20, 3, "R5");
      run_segment(2'b01, 32, 24, 3, "R2");
      run_segment(2'b01, 24, 24, 3, "R2");
      run_segment(2'b10, 32, 24, 3, "R3");
      run_segment(2'b10, 24, 24, 3, "R3");
      run_segment(2'b11, 32, 16, 3, "R4");
      run_segment(2'b11, 16, 16, 3, "R4");
      run_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule